// File: doc/BRIEF.md
# Multilevel Space-Vector Triangle Locator

This block classifies one modulation reference vector per strobe. The vector is given as two signed fixed-point components, a horizontal part `in_vd` and a vertical part `in_vq`. It has already been rotated into the first 60-degree sextant of the space-vector hexagon, and it is normalised so that the sextant's corner vertex sits at (1, 0). The sextant is cut into (L-1)^2 small equilateral triangles, where L is the converter level count chosen at compile time (3 or 4). The block reports the number of the triangle that contains the tip of the vector. A duty-ratio stage downstream uses that number to pick the three nearest switching states.

The block computes no angles and uses no tables. It forms two shared terms, Vq - sqrt3*Vd and Vq + sqrt3*Vd, once. It compares these terms and Vq against the interior grid lines. Only the sign bits of those 3L-5 comparisons are kept. A fixed priority chain of AND/XOR expressions over the sign bits then names the triangle. An inside test that multiplies the signs of a triangle's sides reduces to exactly these gates.

Top module: `svm_tri_locator`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears `out_valid`, `out_tri` and `out_err` to 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` high, two clock edges later. `out_valid` is never high without such an input.
- R3: With LEVELS=3, a vector strictly inside a triangle is reported as follows. The inputs are signed, with 10 fractional bits, and s = sqrt3/2. Let b = floor((Vq+sqrt3*Vd)/s), a = floor((sqrt3*Vd-Vq)/s) and r = floor(2*Vq/s). Then (b,a,r) = (1,1,0) gives 1, (1,0,0) gives 2, (1,0,1) gives 3, and (0,0,0) gives 4.
- R4: With LEVELS=4, the same quantities are used with s = sqrt3/3. Then (b,a,r) = (2,2,0) gives 1, (2,1,0) gives 2, (2,1,1) gives 3, (2,0,1) gives 4, (2,0,2) gives 5, (1,1,0) gives 6, (1,0,0) gives 7, (0,0,0) gives 8, and (1,0,1) gives 9. `out_err` is 0 for all of these.
- R5: Over a sweep of the sextant interior, every triangle number of the selected level is produced at least once.
- R6: With LEVELS=3, a vector beyond the outer edge of the sextant is still given a number from 1 to 4, with `out_err` at 0. For example, (Vd, Vq) = (1.0, 0.5) is reported as 4.
- R7: With LEVELS=4, a vector that matches no line of the chain is reported as triangle 0 with `out_err` at 1. For example, (Vd, Vq) = (0.5, 1.2) gives this result.
- R8: `out_tri` and `out_err` keep their last values in every cycle where `out_valid` is low. The inputs present in those cycles do not change them.
- R9: Strobes on consecutive cycles, with idle cycles mixed in, are each answered in order at the same two-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: a new vector is present on `in_vd`/`in_vq` |
| in_vd | input | 16 | Horizontal component, signed, 10 fractional bits |
| in_vq | input | 16 | Vertical component, signed, 10 fractional bits |
| out_valid | output | 1 | Strobe: `out_tri`/`out_err` carry a new result |
| out_tri | output | 4 | Triangle number (0 only with `out_err`) |
| out_err | output | 1 | No chain line matched (four-level only) |

## Verification
The bound checker checks the timing contract on every cycle: the two-cycle strobe latency, the clearing by reset, and the holding of the result between strobes. It also checks the legal output ranges: 1 to 4 with no error for three levels, and 0 paired with the error flag for four levels. Whether the number reported is the right triangle is shown only by the bench. The bench sweeps a grid over the sextant for both level counts. It compares each result with a lattice model in floating point and skips points that lie near a grid line. It also covers points outside the sextant, streaming with gaps, and a reset that lands between an input and its result.

// File: rtl/svm_loc_pkg.sv
package svm_loc_pkg;

  localparam int TRI_W = 4;

  typedef struct packed {
    logic             err;
    logic [TRI_W-1:0] num;
  } tri_res_t;

  // round(sqrt(3) * 2^frac), computed bitwise
  function automatic longint sqrt3_fixed(int frac);
    longint x;
    longint r;
    x = longint'(3) << (2 * frac);
    r = 0;
    for (int bt = 24; bt >= 0; bt--) begin
      longint t;
      t = r | (longint'(1) << bt);
      if (t * t <= x) r = t;
    end
    if ((2 * r + 1) * (2 * r + 1) < 4 * x) r = r + 1;
    return r;
  endfunction

  // round(sq3 * num / den) in the same scaling as sq3
  function automatic longint grid_thr(longint sq3, int num, int den);
    return (sq3 * longint'(num) + longint'(den / 2)) / longint'(den);
  endfunction

endpackage

// File: rtl/svm_loc_terms.sv
module svm_loc_terms #(
  parameter int LEVELS = 4,
  parameter int DW     = 16,
  parameter int FRAC   = 10,
  localparam int NH    = LEVELS - 2,
  localparam int NB    = LEVELS - 1,
  localparam int NA    = LEVELS - 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_vd,
  input  logic signed [DW-1:0] in_vq,
  output logic                 s_valid,
  output logic [NH-1:0]        h_neg,
  output logic [NB-1:0]        b_neg,
  output logic [NA-1:0]        a_neg
);
  localparam int     PW  = DW + FRAC + 2;
  localparam int     WW  = DW + 3;
  localparam longint SQ3 = svm_loc_pkg::sqrt3_fixed(FRAC);

  logic signed [PW-1:0] vd_x, sq3_x, prod;
  logic signed [WW-1:0] root_vd, vq_x, term_a, term_b;
  logic [NH-1:0] h_nxt;
  logic [NB-1:0] b_nxt;
  logic [NA-1:0] a_nxt;

  assign vd_x    = PW'(in_vd);
  assign sq3_x   = PW'(SQ3);
  assign prod    = vd_x * sq3_x;
  assign root_vd = WW'(prod >>> FRAC);
  assign vq_x    = WW'(in_vq);
  assign term_a  = vq_x - root_vd;
  assign term_b  = vq_x + root_vd;

  // horizontal lines at i*sqrt3/(2(L-1)), i = 1..L-2
  for (genvar i = 0; i < NH; i++) begin : g_h
    localparam logic signed [WW-1:0] K = WW'(svm_loc_pkg::grid_thr(SQ3, i + 1, 2 * (LEVELS - 1)));
    logic signed [WW-1:0] d;
    assign d        = vq_x - K;
    assign h_nxt[i] = d[WW-1];
  end

  // rising lines B = i*sqrt3/(L-1), i = 1..L-1 (last one is the outer edge)
  for (genvar i = 0; i < NB; i++) begin : g_b
    localparam logic signed [WW-1:0] K = WW'(svm_loc_pkg::grid_thr(SQ3, i + 1, LEVELS - 1));
    logic signed [WW-1:0] d;
    assign d        = term_b - K;
    assign b_nxt[i] = d[WW-1];
  end

  // falling lines A = -i*sqrt3/(L-1), i = 1..L-2
  for (genvar i = 0; i < NA; i++) begin : g_a
    localparam logic signed [WW-1:0] K = WW'(svm_loc_pkg::grid_thr(SQ3, i + 1, LEVELS - 1));
    logic signed [WW-1:0] d;
    assign d        = term_a + K;
    assign a_nxt[i] = d[WW-1];
  end

  always_ff @(posedge clk) begin
    if (rst) s_valid <= 1'b0;
    else     s_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      h_neg <= h_nxt;
      b_neg <= b_nxt;
      a_neg <= a_nxt;
    end
  end

endmodule

// File: rtl/svm_loc_decode.sv
module svm_loc_decode #(
  parameter int LEVELS = 4,
  localparam int NH    = LEVELS - 2,
  localparam int NB    = LEVELS - 1,
  localparam int NA    = LEVELS - 2,
  localparam int TW    = svm_loc_pkg::TRI_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  input  logic [NH-1:0] h_neg,
  input  logic [NB-1:0] b_neg,
  input  logic [NA-1:0] a_neg,
  output logic          out_valid,
  output logic [TW-1:0] out_tri,
  output logic          out_err
);
  svm_loc_pkg::tri_res_t res_nxt;

  if (LEVELS == 3) begin : g_l3
    logic h1, a1, b1, b2;
    assign h1 = h_neg[0];
    assign a1 = a_neg[0];
    assign b1 = b_neg[0];
    assign b2 = b_neg[1];
    always_comb begin
      res_nxt.err = 1'b0;
      if (a1 && b2)                    res_nxt.num = TW'(1);
      else if ((h1 ^ a1) && (h1 ^ b1)) res_nxt.num = TW'(2);
      else if (!h1 && b2)              res_nxt.num = TW'(3);
      else                             res_nxt.num = TW'(4);
    end
  end else if (LEVELS == 4) begin : g_l4
    logic h1, h2, a1, a2, b1, b2, b3;
    assign h1 = h_neg[0];
    assign h2 = h_neg[1];
    assign a1 = a_neg[0];
    assign a2 = a_neg[1];
    assign b1 = b_neg[0];
    assign b2 = b_neg[1];
    assign b3 = b_neg[2];
    always_comb begin
      res_nxt.err = 1'b0;
      if (b3 && a2)                    res_nxt.num = TW'(1);
      else if ((h1 ^ a2) && (h1 ^ b2)) res_nxt.num = TW'(2);
      else if ((h1 ^ b3) && (h1 ^ a1)) res_nxt.num = TW'(3);
      else if ((h2 ^ b2) && (h2 ^ a1)) res_nxt.num = TW'(4);
      else if (!h2 && b3)              res_nxt.num = TW'(5);
      else if (b2 && a1)               res_nxt.num = TW'(6);
      else if ((h1 ^ b1) && (h1 ^ a1)) res_nxt.num = TW'(7);
      else if (h1 && b2)               res_nxt.num = TW'(8);
      else if (b3)                     res_nxt.num = TW'(9);
      else begin
        res_nxt.num = '0;
        res_nxt.err = 1'b1;
      end
    end
  end else begin : g_unsupported
    $error("svm_loc_decode: LEVELS must be 3 or 4");
    assign res_nxt = '{err: 1'b1, num: '0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_tri   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= s_valid;
      if (s_valid) begin
        out_tri <= res_nxt.num;
        out_err <= res_nxt.err;
      end
    end
  end

endmodule

// File: rtl/svm_tri_locator.sv
module svm_tri_locator #(
  parameter int LEVELS = 4,
  parameter int DW     = 16,
  parameter int FRAC   = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_vd,
  input  logic signed [DW-1:0] in_vq,
  output logic                 out_valid,
  output logic [3:0]           out_tri,
  output logic                 out_err
);
  localparam int NH = LEVELS - 2;
  localparam int NB = LEVELS - 1;
  localparam int NA = LEVELS - 2;

  logic          s_valid;
  logic [NH-1:0] h_neg;
  logic [NB-1:0] b_neg;
  logic [NA-1:0] a_neg;

  svm_loc_terms #(.LEVELS(LEVELS), .DW(DW), .FRAC(FRAC)) u_terms (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_vd    (in_vd),
    .in_vq    (in_vq),
    .s_valid  (s_valid),
    .h_neg    (h_neg),
    .b_neg    (b_neg),
    .a_neg    (a_neg)
  );

  svm_loc_decode #(.LEVELS(LEVELS)) u_decode (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s_valid),
    .h_neg     (h_neg),
    .b_neg     (b_neg),
    .a_neg     (a_neg),
    .out_valid (out_valid),
    .out_tri   (out_tri),
    .out_err   (out_err)
  );

endmodule

// File: rtl/svm_tri_locator_chk.sv
module svm_tri_locator_chk #(
  parameter int LEVELS = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       out_valid,
  input logic [3:0] out_tri,
  input logic       out_err
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_tri == 4'd0 && !out_err));

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !out_valid) |-> ($stable(out_tri) && $stable(out_err)));

  if (LEVELS == 3) begin : g_l3
    a_r6_l3_always_found: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_tri >= 4'd1 && out_tri <= 4'd4 && !out_err));
  end else begin : g_l4
    a_r7_err_zero: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_err) |-> (out_tri == 4'd0));
    a_r4_l4_range: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_err) |-> (out_tri >= 4'd1 && out_tri <= 4'd9));
  end

endmodule

bind svm_tri_locator svm_tri_locator_chk #(.LEVELS(LEVELS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_tri   (out_tri),
  .out_err   (out_err)
);

// File: tb/tb_svm_tri_locator.sv
`timescale 1ns/1ps
module tb_svm_tri_locator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_vd = '0;
  logic signed [15:0] in_vq = '0;
  logic       o4_v, o4_e, o3_v, o3_e;
  logic [3:0] o4_t, o3_t;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int hit3[5];
  int hit4[10];

  always #10 clk = ~clk;

  svm_tri_locator #(.LEVELS(4)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vd(in_vd), .in_vq(in_vq),
    .out_valid(o4_v), .out_tri(o4_t), .out_err(o4_e));

  svm_tri_locator #(.LEVELS(3)) dut_l3 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vd(in_vd), .in_vq(in_vq),
    .out_valid(o3_v), .out_tri(o3_t), .out_err(o3_e));

  task automatic chk(bit cond, string req, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lattice model of the sextant (R3/R4); ok=0 near any grid line or outside
  function automatic int expect_tri(int lv, int vdi, int vqi, output bit ok);
    real sq3, vd, vq, s, x, y, z, m;
    int b, a, r, key, t;
    sq3 = $sqrt(3.0);
    vd  = vdi / 1024.0;
    vq  = vqi / 1024.0;
    s   = sq3 / (lv - 1);
    x   = (vq + sq3 * vd) / s;
    y   = (sq3 * vd - vq) / s;
    z   = 2.0 * vq / s;
    m   = 0.02;
    b   = int'($floor(x));
    a   = int'($floor(y));
    r   = int'($floor(z));
    ok  = (x - b > m) && (b + 1 - x > m) && (y - a > m) && (a + 1 - y > m) &&
          (z - r > m) && (r + 1 - z > m) && (y > m) && (z > m) && (x < lv - 1 - m);
    key = b * 100 + a * 10 + r;
    t   = -1;
    if (lv == 3) begin
      case (key)
        110: t = 1;
        100: t = 2;
        101: t = 3;
        0:   t = 4;
        default: t = -1;
      endcase
    end else begin
      case (key)
        220: t = 1;
        210: t = 2;
        211: t = 3;
        201: t = 4;
        202: t = 5;
        110: t = 6;
        100: t = 7;
        0:   t = 8;
        101: t = 9;
        default: t = -1;
      endcase
    end
    return t;
  endfunction

  // one isolated strobe; checks the R2 timing and returns both results
  task automatic drive_pt(int vdi, int vqi,
                          output int t4, output int e4, output int t3, output int e3);
    @(negedge clk);
    in_valid = 1'b1;
    in_vd    = 16'(vdi);
    in_vq    = 16'(vqi);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!o4_v && !o3_v, "R2 no result after one cycle", int'(o4_v) + int'(o3_v), 0);
    @(negedge clk);
    chk(o4_v && o3_v, "R2 result after two cycles", int'(o4_v) + int'(o3_v), 2);
    t4 = int'(o4_t); e4 = int'(o4_e);
    t3 = int'(o3_t); e3 = int'(o3_e);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t4, e4, t3, e3;
    int sv[3];
    int se4[3];
    int se3[3];
    bit sok4[3];
    bit sok3[3];
    bit k4, k3;
    int x4, x3;

    foreach (hit3[i]) hit3[i] = 0;
    foreach (hit4[i]) hit4[i] = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!o4_v && o4_t == 4'd0 && !o4_e, "R1 reset state l4", int'(o4_t), 0);
    chk(!o3_v && o3_t == 4'd0 && !o3_e, "R1 reset state l3", int'(o3_t), 0);

    // R3/R4: sweep over the sextant
    for (int vdi = 0; vdi <= 1024; vdi += 16) begin
      for (int vqi = 0; vqi <= 900; vqi += 12) begin
        x4 = expect_tri(4, vdi, vqi, k4);
        x3 = expect_tri(3, vdi, vqi, k3);
        if (k4 || k3) begin
          drive_pt(vdi, vqi, t4, e4, t3, e3);
          if (k4) begin
            chk(t4 == x4 && e4 == 0, "R4 four-level triangle", t4, x4);
            if (t4 >= 1 && t4 <= 9) hit4[t4]++;
          end
          if (k3) begin
            chk(t3 == x3 && e3 == 0, "R3 three-level triangle", t3, x3);
            if (t3 >= 1 && t3 <= 4) hit3[t3]++;
          end
        end
      end
    end

    // R5: every triangle reached
    for (int i = 1; i <= 4; i++) chk(hit3[i] > 0, "R5 three-level coverage", hit3[i], 1);
    for (int i = 1; i <= 9; i++) chk(hit4[i] > 0, "R5 four-level coverage", hit4[i], 1);

    // R6: three-level, beyond the outer edge
    drive_pt(1024, 512, t4, e4, t3, e3);
    chk(t3 >= 1 && t3 <= 4, "R6 outside still numbered", t3, 4);
    chk(e3 == 0, "R6 outside no error", e3, 0);

    // R7: four-level, no chain match
    drive_pt(512, 1229, t4, e4, t3, e3);
    chk(t4 == 0, "R7 no-match triangle", t4, 0);
    chk(e4 == 1, "R7 no-match error flag", e4, 1);

    // R9: streaming with gaps (every fourth slot idle)
    for (int c = 0; c < 62; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        int p;
        p = (c - 2) % 3;
        chk(int'(o4_v) == sv[p], "R9 stream strobe l4", int'(o4_v), sv[p]);
        chk(int'(o3_v) == sv[p], "R9 stream strobe l3", int'(o3_v), sv[p]);
        if (sv[p] == 1 && sok4[p]) chk(int'(o4_t) == se4[p], "R9 stream triangle l4", int'(o4_t), se4[p]);
        if (sv[p] == 1 && sok3[p]) chk(int'(o3_t) == se3[p], "R9 stream triangle l3", int'(o3_t), se3[p]);
      end
      begin
        int q, vdi;
        q   = c % 3;
        vdi = 90 + c * 14;
        if (c < 60 && (c % 4) != 3) begin
          in_valid = 1'b1;
          in_vd    = 16'(vdi);
          in_vq    = 16'(148);
          sv[q]    = 1;
          se4[q]   = expect_tri(4, vdi, 148, k4);
          se3[q]   = expect_tri(3, vdi, 148, k3);
          sok4[q]  = k4;
          sok3[q]  = k3;
        end else begin
          in_valid = 1'b0;
          sv[q]    = 0;
          sok4[q]  = 0;
          sok3[q]  = 0;
        end
      end
    end
    in_valid = 1'b0;

    // R8: results hold while idle inputs move
    drive_pt(205, 102, t4, e4, t3, e3);
    chk(t4 == 8, "R8 setup l4", t4, 8);
    chk(t3 == 4, "R8 setup l3", t3, 4);
    in_vd = 16'(900);
    in_vq = 16'(50);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!o4_v && int'(o4_t) == 8 && !o4_e, "R8 hold l4", int'(o4_t), 8);
      chk(!o3_v && int'(o3_t) == 4 && !o3_e, "R8 hold l3", int'(o3_t), 4);
    end

    // R1: reset between an input and its result
    @(negedge clk);
    in_valid = 1'b1;
    in_vd    = 16'(205);
    in_vq    = 16'(102);
    @(negedge clk);
    in_valid = 1'b0;
    rst      = 1'b1;
    @(negedge clk);
    chk(!o4_v && o4_t == 4'd0 && !o4_e, "R1 mid-run reset l4", int'(o4_v), 0);
    chk(!o3_v && o3_t == 4'd0 && !o3_e, "R1 mid-run reset l3", int'(o3_v), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!o4_v && !o3_v, "R2 no strobe without input", int'(o4_v) + int'(o3_v), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule